// File: doc/BRIEF.md
# Heartbeat Stall Detector

This block supervises a link to a remote communication client through a one-byte heartbeat register. The client writes that register and is expected to step its value about once per second. The block keeps a local seconds count from a one-pulse-per-second tick. At the end of each check period it samples the register and compares the sample with the one taken at the previous check. If the two samples are equal, the client has stopped advancing the heartbeat, and the block raises a communication-loss alarm.

The check period is a configuration input in seconds. It is meant to be several times the client's one-second step, so that a live client always changes the value between two checks. Values below two are raised to two. The alarm stays set until a later check sees the heartbeat move again, or until the clear input is pulsed.

Top module: `hb_stall_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its idle state: `alarm` is 0, the seconds count is zero, and no earlier sample is held.
- R2: With an effective check period of P, a sample is taken on every P-th cycle in which `sec_tick` is high, counted from reset. Cycles without a tick do not advance the count.
- R3: The first sample after reset only stores the heartbeat value and never sets `alarm`, even when that value equals the reset value 0.
- R4: When a sample equals the previous sample, `alarm` is 1 in the cycle after the sampling cycle.
- R5: A heartbeat step from 255 to 0 counts as a change. A sample of 0 following a sample of 255 does not set `alarm`.
- R6: Once set, `alarm` stays 1 until a later sample differs from the one before it, or until a clear pulse arrives. In the cycle after such a differing sample, `alarm` is 0.
- R7: A cycle with `alarm_clr` high makes `alarm` 0 in the next cycle. If a sample in that same cycle finds the heartbeat unchanged, the new detection wins and `alarm` is 1.
- R8: A heartbeat write in the same cycle as a sample is not part of that sample. The sample uses the value held before the write, and the written value is first compared at the next sample.
- R9: A `check_period` value of 0 or 1 behaves as a period of 2 ticks.
- R10: Only the heartbeat value held when a sample is taken is compared. Several writes between two samples that end on the previous sampled value count as no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hb_wr_en | input | 1 | Heartbeat register write strobe |
| hb_wr_data | input | 8 | Heartbeat value to write |
| sec_tick | input | 1 | One-cycle pulse per second |
| check_period | input | 8 | Check period in seconds (minimum 2) |
| alarm_clr | input | 1 | Alarm clear pulse |
| alarm | output | 1 | Communication-loss alarm |

## Verification
The bench targets the samples near reset and the byte wrap. A design that compared its first sample against the reset value would raise a false alarm on a client that happened to start at 0. A design that used an ordered greater-than test would flag the step from 255 to 0. A write placed on the exact sampling tick shows whether the register value is sampled before or after the write. A design that sampled after the write would miss a stall that a one-cycle-late write should not hide. Period values of 0 and 1, a clear that meets a fresh stall in the same cycle, and a burst of writes that lands back on the old value round out the cases. Each of these would show as an alarm edge in the wrong cycle.

// File: rtl/hb_pkg.sv
// Package hb_pkg
// Shared widths and the event record passed from the sample comparator to
// the alarm latch. Assumes an 8-bit heartbeat and an 8-bit period field.
package hb_pkg;
    localparam int HB_W_DEF       = 8;
    localparam int PERIOD_W_DEF   = 8;
    localparam int MIN_PERIOD_DEF = 2;

    // Outcome of one compared sample (both low when no comparison happened)
    typedef struct packed {
        logic stall;   // sample equal to the previous one
        logic moved;   // sample differs from the previous one
    } cmp_evt_t;
endpackage

// File: rtl/hb_store.sv
// Module hb_store
// Holds the heartbeat byte written by the remote client. A write becomes
// visible in the cycle after the strobe. Assumes one writer.
module hb_store #(
    parameter int HB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [HB_W-1:0] wr_data,
    output logic [HB_W-1:0] hb_value
);
    logic [HB_W-1:0] hb_q;

    // Capture the written heartbeat value
    always_ff @(posedge clk) begin
        if (!rst_n)     hb_q <= '0;
        else if (wr_en) hb_q <= wr_data;
    end

    assign hb_value = hb_q;

    // R8: the value held changes only after a write strobe
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> hb_q == $past(hb_q));
endmodule

// File: rtl/hb_tick_timer.sv
// Module hb_tick_timer
// Counts second ticks and fires a one-cycle sample strobe on every
// effective-period-th tick. The configured period is raised to MIN_PERIOD.
// If the period shrinks mid-count, the next tick fires at once.
module hb_tick_timer #(
    parameter int PERIOD_W   = 8,
    parameter int MIN_PERIOD = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic [PERIOD_W-1:0] period_cfg,
    output logic                sample_stb
);
    localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);
    localparam logic [PERIOD_W-1:0] ONE   = PERIOD_W'(1);

    logic [PERIOD_W-1:0] eff_period;
    logic [PERIOD_W-1:0] tick_cnt;
    logic                last_tick;

    // Clamp the configured period to the allowed minimum
    always_comb begin
        eff_period = (period_cfg < MIN_P) ? MIN_P : period_cfg;
        last_tick  = (tick_cnt >= (eff_period - ONE));
    end

    assign sample_stb = sec_tick && last_tick;

    // Advance the tick count, wrapping at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n)        tick_cnt <= '0;
        else if (sec_tick) tick_cnt <= last_tick ? '0 : tick_cnt + ONE;
    end

    // R2: a tick that does not end the period advances the count by one
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !sample_stb) |=> tick_cnt == $past(tick_cnt) + ONE);

    // R9: at least one earlier tick must be counted before any sample
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> tick_cnt != '0);

    // R2: count holds in cycles without a tick
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(tick_cnt));
endmodule

// File: rtl/hb_compare.sv
// Module hb_compare
// On each sample strobe, compares the heartbeat with the previously
// sampled value and reports stall or movement. The first strobe after
// reset only primes the previous-value register. Equality alone decides,
// so a modular wrap counts as movement.
module hb_compare
    import hb_pkg::*;
#(
    parameter int HB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_stb,
    input  logic [HB_W-1:0] hb_value,
    output cmp_evt_t        evt
);
    logic [HB_W-1:0] prev_q;
    logic            primed_q;
    logic            same;

    // Equality of the live value with the stored sample
    always_comb begin
        same      = (hb_value == prev_q);
        evt.stall = sample_stb && primed_q && same;
        evt.moved = sample_stb && primed_q && !same;
    end

    // Store every sample and remember that one has been taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (sample_stb) begin
            prev_q   <= hb_value;
            primed_q <= 1'b1;
        end
    end

    // R3: the first sample primes the stored value without an event
    prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !primed_q) |=> primed_q && prev_q == $past(hb_value));

    // R4: stall and movement are never reported together
    excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.stall && evt.moved));
endmodule

// File: rtl/hb_alarm.sv
// Module hb_alarm
// Alarm latch: set by a stall event, cleared by a movement event or by
// the clear input. A stall in the same cycle as a clear keeps it set.
module hb_alarm
    import hb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmp_evt_t evt,
    input  logic     clr,
    output logic     alarm
);
    logic alarm_q;

    // Update the alarm from this cycle's events
    always_ff @(posedge clk) begin
        if (!rst_n)              alarm_q <= 1'b0;
        else if (evt.stall)      alarm_q <= 1'b1;
        else if (clr || evt.moved) alarm_q <= 1'b0;
    end

    assign alarm = alarm_q;

    // R4: a stall event raises the alarm in the next cycle
    stall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stall |=> alarm_q);

    // R6: without clear or movement the alarm holds
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !clr && !evt.moved) |=> alarm_q);

    // R7: a clear without a fresh stall drops the alarm
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt.stall) |=> !alarm_q);
endmodule

// File: rtl/hb_stall_monitor.sv
// Module hb_stall_monitor
// Top level of the heartbeat stall detector: heartbeat store, tick timer,
// sample comparator and alarm latch. Assumes sec_tick is a one-cycle pulse
// per second and check_period is held steady in normal use.
module hb_stall_monitor
    import hb_pkg::*;
#(
    parameter int HB_W       = HB_W_DEF,
    parameter int PERIOD_W   = PERIOD_W_DEF,
    parameter int MIN_PERIOD = MIN_PERIOD_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hb_wr_en,
    input  logic [HB_W-1:0]     hb_wr_data,
    input  logic                sec_tick,
    input  logic [PERIOD_W-1:0] check_period,
    input  logic                alarm_clr,
    output logic                alarm
);
    logic [HB_W-1:0] hb_value;
    logic            sample_stb;
    cmp_evt_t        evt;

    hb_store #(.HB_W(HB_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hb_wr_en),
        .wr_data  (hb_wr_data),
        .hb_value (hb_value)
    );

    hb_tick_timer #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .period_cfg (check_period),
        .sample_stb (sample_stb)
    );

    hb_compare #(.HB_W(HB_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .hb_value   (hb_value),
        .evt        (evt)
    );

    hb_alarm u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (alarm_clr),
        .alarm (alarm)
    );

    // R1: the cycle after a reset edge shows no alarm
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !alarm);
endmodule

// File: tb/tb_hb_stall_monitor.sv
module tb_hb_stall_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hb_wr_en = 1'b0;
    logic [7:0] hb_wr_data = '0;
    logic       sec_tick = 1'b0;
    logic [7:0] check_period = 8'd3;
    logic       alarm_clr = 1'b0;
    logic       alarm;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_hb = 0, m_cnt = 0, m_prev = 0, m_alarm = 0;
    bit m_primed = 0;

    always #4 clk = ~clk;

    hb_stall_monitor dut (
        .clk(clk), .rst_n(rst_n), .hb_wr_en(hb_wr_en), .hb_wr_data(hb_wr_data),
        .sec_tick(sec_tick), .check_period(check_period),
        .alarm_clr(alarm_clr), .alarm(alarm)
    );

    // reference model, evaluated from the inputs present at each edge
    always @(posedge clk) begin
        int  eff;
        bit  samp, stall, moved;
        if (!rst_n) begin
            m_hb = 0; m_cnt = 0; m_prev = 0; m_alarm = 0; m_primed = 0;
        end else begin
            eff = (check_period < 2) ? 2 : int'(check_period);
            samp = 0; stall = 0; moved = 0;
            if (sec_tick) begin
                if (m_cnt + 1 >= eff) begin samp = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (samp) begin
                if (m_primed) begin
                    stall = (m_hb == m_prev);
                    moved = !stall;
                end
                m_prev = m_hb;
                m_primed = 1;
            end
            if (stall) m_alarm = 1;
            else if (alarm_clr || moved) m_alarm = 0;
            if (hb_wr_en) m_hb = int'(hb_wr_data);
        end
    end

    // compare against the model in the middle of every cycle
    always @(negedge clk) begin
        if (!finished) begin
            total++;
            if (alarm !== m_alarm[0]) begin
                bad++;
                $display("FAIL %s per-cycle alarm: actual=%0b expected=%0d at %0t",
                         cur_req, alarm, m_alarm, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one tick, with optional write and clear in the same cycle, then a gap
    task automatic tick(input bit wr, input int data, input bit clr);
        @(negedge clk);
        sec_tick = 1; hb_wr_en = wr; hb_wr_data = 8'(data); alarm_clr = clr;
        @(negedge clk);
        sec_tick = 0; hb_wr_en = 0; alarm_clr = 0;
        idle(1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic write(input int data);
        @(negedge clk);
        hb_wr_en = 1; hb_wr_data = 8'(data);
        @(negedge clk);
        hb_wr_en = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        alarm_clr = 1;
        @(negedge clk);
        alarm_clr = 0;
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        chk(alarm == 0, "R1", alarm, 0);
        rst_n = 1;
        idle(2);

        // R3 then R4 with period 3 and heartbeat never written
        cur_req = "R3";
        ticks(3);
        chk(alarm == 0, "R3", alarm, 0);
        cur_req = "R2";
        ticks(2);
        chk(alarm == 0, "R2", alarm, 0);
        cur_req = "R4";
        ticks(1);
        chk(alarm == 1, "R4", alarm, 1);

        // R6: holds, then clears on movement
        cur_req = "R6";
        idle(20);
        chk(alarm == 1, "R6", alarm, 1);
        write(5);
        ticks(3);
        chk(alarm == 0, "R6", alarm, 0);

        // R7: clear pulse, then clear meeting a stall
        cur_req = "R7";
        ticks(3);
        chk(alarm == 1, "R4", alarm, 1);
        pulse_clr();
        idle(1);
        chk(alarm == 0, "R7", alarm, 0);
        ticks(2);
        tick(0, 0, 1);
        chk(alarm == 1, "R7", alarm, 1);

        // R5: wrap 255 -> 0 is a change
        cur_req = "R5";
        write(255);
        ticks(3);
        chk(alarm == 0, "R5", alarm, 0);
        write(0);
        ticks(3);
        chk(alarm == 0, "R5", alarm, 0);

        // R8: write on the sampling tick is seen one sample later
        cur_req = "R8";
        ticks(2);
        tick(1, 9, 0);
        chk(alarm == 1, "R8", alarm, 1);
        ticks(3);
        chk(alarm == 0, "R8", alarm, 0);

        // R9: period 0 and 1 behave as 2
        cur_req = "R9";
        check_period = 8'd0;
        ticks(1);
        chk(alarm == 0, "R9", alarm, 0);
        ticks(1);
        chk(alarm == 1, "R9", alarm, 1);
        write(10);
        ticks(2);
        chk(alarm == 0, "R9", alarm, 0);
        check_period = 8'd1;
        ticks(2);
        chk(alarm == 1, "R9", alarm, 1);

        // R10: writes that end on the old value are no change
        cur_req = "R10";
        write(11);
        write(10);
        ticks(2);
        chk(alarm == 1, "R10", alarm, 1);

        // R1/R3 again: mid-run reset, first sample only primes
        cur_req = "R1";
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk(alarm == 0, "R1", alarm, 0);
        rst_n = 1;
        cur_req = "R3";
        check_period = 8'd2;
        ticks(2);
        chk(alarm == 0, "R3", alarm, 0);

        // R2: mixed traffic against the model
        cur_req = "R2";
        check_period = 8'd4;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            sec_tick   = ($urandom % 4) == 0;
            hb_wr_en   = ($urandom % 9) == 0;
            hb_wr_data = 8'($urandom % 3);
            alarm_clr  = ($urandom % 50) == 0;
            if ((i % 1000) == 999) check_period = 8'($urandom % 6);
        end
        @(negedge clk);
        sec_tick = 0; hb_wr_en = 0; alarm_clr = 0;
        idle(2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule